// File: doc/BRIEF.md
# Power-Pulsed Conversion Scheduler

This block steers the converter power and conversion strobes of a multi-channel calorimeter readout chip over a repeating acquisition frame. A start pulse opens a frame, which runs through a fixed-length acquisition phase, a fixed-length conversion window and a fixed-length readout phase, and then rests in idle until the next start pulse. All phase lengths are parameters counted in system clock ticks, so a simulation can shorten the frame.

Every channel owns a converter. At the moment the conversion window opens, the block latches each channel's trigger flag and its count of stored analog samples. Only a channel that has triggered and holds at least one sample gets its converter powered. That converter waits a recovery interval, then issues one start-of-conversion strobe per stored sample. Each strobe after the first follows the done pulse of the conversion before it. All active channels run in parallel. Power is removed after the last conversion finishes, or at the end of the window, whichever comes first. A conversion that is still outstanding when the window closes raises a per-channel overrun flag.

Top module: `pp_conv_sched`

## Requirements
- R1: After reset the idle indicator is 1. The other three phase indicators, every power enable, every strobe and every overrun flag are 0.
- R2: A start pulse seen in idle gives exactly ACQ_TICKS cycles of acquisition, then CONV_TICKS cycles of conversion, then READ_TICKS cycles of readout, and then idle until the next start pulse. Exactly one phase indicator is 1 in every cycle.
- R3: A start pulse that arrives outside idle has no effect on the phase lengths.
- R4: Trigger flags and sample counts are sampled only at the last acquisition cycle. Changes to them during the conversion window have no effect.
- R5: A channel's power enable rises on the first conversion-window cycle only if its trigger flag was 1 and its sample count was nonzero. Any other channel stays unpowered for the whole frame.
- R6: A channel's first strobe comes exactly RECOV_TICKS cycles after its power enable rises.
- R7: A strobe lasts one cycle and appears only while the channel is powered. The next strobe comes in the cycle after the done pulse of the conversion before it.
- R8: A channel issues one strobe per stored sample, up to the number that fits in the window. A sample count above MAX_SAMP is treated as MAX_SAMP.
- R9: Power drops in the cycle after the done pulse of the channel's last conversion.
- R10: At the end of the window, power is forced off. The channel's overrun flag is set if a strobe has been issued and its done pulse had not arrived by the last window cycle. The flag is held until the next acquisition begins.
- R11: Power enables and strobes are 0 in every cycle outside the conversion window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Frame start pulse, honoured in idle only |
| ch_trig | input | N_CH | Per-channel trigger flags |
| ch_samples | input | N_CH*$clog2(MAX_SAMP+1) | Per-channel stored sample counts, channel 0 in the low bits |
| conv_done | input | N_CH | Per-channel conversion-finished pulses |
| adc_pwr | output | N_CH | Per-channel converter power enables |
| adc_soc | output | N_CH | Per-channel start-of-conversion strobes |
| ch_overrun | output | N_CH | Per-channel window-overrun flags |
| ph_acq | output | 1 | Acquisition phase indicator |
| ph_conv | output | 1 | Conversion window indicator |
| ph_read | output | 1 | Readout phase indicator |
| ph_idle | output | 1 | Idle phase indicator |

## Verification
All outputs are registered, so every result is due one clock edge after the stimulus that causes it. The start pulse is seen as acquisition in the following cycle. Power rises in the first window cycle, and the first strobe follows RECOV_TICKS cycles after that. A done pulse driven in window cycle t gives the next strobe, or the power drop, in cycle t+1. The overrun flag shows in the first readout cycle. The bench counts window cycles from the first one and drives done pulses a set latency after each observed strobe. It works out the strobe times as RECOV_TICKS+1+i*(latency+1) and derives from them the strobe counts, power-on cycles and overrun outcome, which it compares with counts taken on the falling edge.

// File: rtl/pp_sched_pkg.sv
package pp_sched_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACQ, PH_CONV, PH_READ} phase_t;
  typedef enum logic [1:0] {CH_OFF, CH_WAKE, CH_SOC, CH_BUSY} chst_t;
endpackage

// File: rtl/pp_frame_seq.sv
module pp_frame_seq
  import pp_sched_pkg::*;
#(
  parameter int ACQ_TICKS  = 250000,
  parameter int CONV_TICKS = 125000,
  parameter int READ_TICKS = 125000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cycle_start,
  output phase_t phase,
  output logic   frame_begin,
  output logic   conv_begin,
  output logic   conv_end
);
  localparam int MAXT = (ACQ_TICKS > CONV_TICKS) ?
                        ((ACQ_TICKS > READ_TICKS) ? ACQ_TICKS : READ_TICKS) :
                        ((CONV_TICKS > READ_TICKS) ? CONV_TICKS : READ_TICKS);
  localparam int TW = $clog2(MAXT + 1);

  logic [TW-1:0] tick_q, tick_d;
  phase_t        phase_d;
  logic          acq_last, conv_last, read_last;

  assign acq_last    = (tick_q == TW'(ACQ_TICKS - 1));
  assign conv_last   = (tick_q == TW'(CONV_TICKS - 1));
  assign read_last   = (tick_q == TW'(READ_TICKS - 1));
  assign frame_begin = (phase == PH_IDLE) && cycle_start;
  assign conv_begin  = (phase == PH_ACQ) && acq_last;
  assign conv_end    = (phase == PH_CONV) && conv_last;

  always_comb begin
    phase_d = phase;
    tick_d  = tick_q + TW'(1);
    case (phase)
      PH_IDLE: begin
        tick_d = '0;
        if (cycle_start) phase_d = PH_ACQ;
      end
      PH_ACQ: if (acq_last) begin
        phase_d = PH_CONV;
        tick_d  = '0;
      end
      PH_CONV: if (conv_last) begin
        phase_d = PH_READ;
        tick_d  = '0;
      end
      default: if (read_last) begin
        phase_d = PH_IDLE;
        tick_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      tick_q <= '0;
    end else begin
      phase  <= phase_d;
      tick_q <= tick_d;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !cycle_start) |=> (phase == PH_IDLE));
  assert_acq_ignores_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACQ) |=> (phase == PH_ACQ || phase == PH_CONV));
  assert_conv_to_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV) |=> (phase == PH_CONV || phase == PH_READ));
  assert_read_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |=> (phase == PH_READ || phase == PH_IDLE));
endmodule

// File: rtl/pp_chan_ctl.sv
module pp_chan_ctl
  import pp_sched_pkg::*;
#(
  parameter int MAX_SAMP    = 5,
  parameter int RECOV_TICKS = 250,
  parameter int CW          = $clog2(MAX_SAMP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_begin,
  input  logic          conv_begin,
  input  logic          conv_end,
  input  logic          in_conv,
  input  logic          trig,
  input  logic [CW-1:0] samples,
  input  logic          conv_done,
  output logic          pwr,
  output logic          soc,
  output logic          overrun
);
  localparam int RW = $clog2(RECOV_TICKS + 1) + 1;
  localparam logic [CW-1:0] MAXS = CW'(MAX_SAMP);

  chst_t         st_q, st_d;
  logic [CW-1:0] rem_q, rem_d, want;
  logic [RW-1:0] rc_q, rc_d;
  logic          ovr_d;

  assign want    = (samples > MAXS) ? MAXS : samples;
  assign pwr     = (st_q != CH_OFF);
  assign soc     = (st_q == CH_SOC);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    rc_d  = rc_q;
    ovr_d = overrun;
    if (frame_begin) ovr_d = 1'b0;
    case (st_q)
      CH_OFF: if (conv_begin && trig && (want != '0)) begin
        st_d  = CH_WAKE;
        rem_d = want;
        rc_d  = '0;
      end
      CH_WAKE: begin
        if (rc_q == RW'(RECOV_TICKS - 1)) st_d = CH_SOC;
        else                              rc_d = rc_q + RW'(1);
      end
      CH_SOC: st_d = CH_BUSY;
      default: if (conv_done) begin
        rem_d = rem_q - CW'(1);
        st_d  = (rem_q == CW'(1)) ? CH_OFF : CH_SOC;
      end
    endcase
    if (conv_end) begin
      st_d = CH_OFF;
      if (st_q == CH_SOC || (st_q == CH_BUSY && !conv_done)) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_OFF;
      rem_q   <= '0;
      rc_q    <= '0;
      overrun <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      rc_q    <= rc_d;
      overrun <= ovr_d;
    end
  end

  // Checker-only age counter: cycles since power rose, saturating.
  logic [RW-1:0] pw_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pw_age <= '0;
    else if (!pwr)                  pw_age <= '0;
    else if (pw_age != {RW{1'b1}})  pw_age <= pw_age + RW'(1);
  end

  assert_soc_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> pwr);
  assert_soc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soc |=> !soc);
  assert_pwr_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |-> in_conv);
  assert_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> (pw_age >= RW'(RECOV_TICKS)));
  assert_overrun_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (!pwr && $past(pwr)));
endmodule

// File: rtl/pp_conv_sched.sv
module pp_conv_sched
  import pp_sched_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int MAX_SAMP    = 5,
  parameter int ACQ_TICKS   = 250000,
  parameter int CONV_TICKS  = 125000,
  parameter int READ_TICKS  = 125000,
  parameter int RECOV_TICKS = 250
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cycle_start,
  input  logic [N_CH-1:0]                      ch_trig,
  input  logic [N_CH*$clog2(MAX_SAMP+1)-1:0]   ch_samples,
  input  logic [N_CH-1:0]                      conv_done,
  output logic [N_CH-1:0]                      adc_pwr,
  output logic [N_CH-1:0]                      adc_soc,
  output logic [N_CH-1:0]                      ch_overrun,
  output logic                                 ph_acq,
  output logic                                 ph_conv,
  output logic                                 ph_read,
  output logic                                 ph_idle
);
  localparam int CW = $clog2(MAX_SAMP + 1);

  phase_t phase;
  logic   frame_begin, conv_begin, conv_end;

  pp_frame_seq #(
    .ACQ_TICKS (ACQ_TICKS),
    .CONV_TICKS(CONV_TICKS),
    .READ_TICKS(READ_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .phase      (phase),
    .frame_begin(frame_begin),
    .conv_begin (conv_begin),
    .conv_end   (conv_end)
  );

  assign ph_idle = (phase == PH_IDLE);
  assign ph_acq  = (phase == PH_ACQ);
  assign ph_conv = (phase == PH_CONV);
  assign ph_read = (phase == PH_READ);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pp_chan_ctl #(
      .MAX_SAMP   (MAX_SAMP),
      .RECOV_TICKS(RECOV_TICKS),
      .CW         (CW)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_begin(frame_begin),
      .conv_begin (conv_begin),
      .conv_end   (conv_end),
      .in_conv    (ph_conv),
      .trig       (ch_trig[g]),
      .samples    (ch_samples[g*CW +: CW]),
      .conv_done  (conv_done[g]),
      .pwr        (adc_pwr[g]),
      .soc        (adc_soc[g]),
      .overrun    (ch_overrun[g])
    );
  end

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ph_idle, ph_acq, ph_conv, ph_read}) == 1);
  assert_no_power_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_conv |-> (adc_pwr == '0 && adc_soc == '0));
  assert_power_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_acq && !adc_pwr[0]) |=> (!adc_pwr[0] || ph_conv));
endmodule

// File: tb/pp_conv_sched_bench.sv
module pp_conv_sched_bench;
  localparam int NC    = 4;
  localparam int MS    = 5;
  localparam int ACQ   = 20;
  localparam int CONV  = 60;
  localparam int READ  = 10;
  localparam int RECOV = 4;
  localparam int CW    = $clog2(MS + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cycle_start;
  logic [NC-1:0] ch_trig, conv_done, adc_pwr, adc_soc, ch_overrun;
  logic [NC*CW-1:0] ch_samples;
  logic ph_acq, ph_conv, ph_read, ph_idle;

  always #2 clk = ~clk;

  pp_conv_sched #(
    .N_CH(NC), .MAX_SAMP(MS), .ACQ_TICKS(ACQ), .CONV_TICKS(CONV),
    .READ_TICKS(READ), .RECOV_TICKS(RECOV)
  ) u_pp_conv_sched (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ch_trig(ch_trig),
    .ch_samples(ch_samples), .conv_done(conv_done), .adc_pwr(adc_pwr),
    .adc_soc(adc_soc), .ch_overrun(ch_overrun), .ph_acq(ph_acq),
    .ph_conv(ph_conv), .ph_read(ph_read), .ph_idle(ph_idle)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  int cfg_cnt [NC];
  int cfg_lat [NC];

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input bit t, input int k);
    return (!t) ? 0 : ((k > MS) ? MS : k);
  endfunction
  function automatic int exp_socs(input int k, input int l);
    int n = 0;
    for (int i = 0; i < k; i++) if (RECOV + 1 + i * (l + 1) <= CONV) n++;
    return n;
  endfunction
  function automatic int exp_pwr(input int k, input int l);
    int last;
    if (k == 0) return 0;
    last = RECOV + 1 + (k - 1) * (l + 1) + l;
    return (last < CONV) ? last : CONV;
  endfunction
  function automatic int exp_ovr(input int k, input int l);
    for (int i = 0; i < k; i++) begin
      int s = RECOV + 1 + i * (l + 1);
      if (s <= CONV && s + l > CONV) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic run_frame(input logic [NC-1:0] tg, input bit extra_start, input bit scramble);
    int acq_n = 0, j = 0, rd_n = 0, multi = 0, outside = 0, ovr_acq = 0, guard = 0;
    int pw [NC], sc [NC], fj [NC], due [NC], ov [NC];
    for (int c = 0; c < NC; c++) begin pw[c] = 0; sc[c] = 0; fj[c] = -1; due[c] = -1; ov[c] = 0; end
    @(negedge clk);
    ch_trig = tg;
    for (int c = 0; c < NC; c++) ch_samples[c*CW +: CW] = CW'(cfg_cnt[c]);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    while (guard < 2000) begin
      guard++;
      if ($countones({ph_idle, ph_acq, ph_conv, ph_read}) != 1) multi++;
      cycle_start = 1'b0;
      if (ph_acq) begin
        acq_n++;
        if (acq_n == 1 && ch_overrun != '0) ovr_acq++;
        if (extra_start && acq_n == 3) cycle_start = 1'b1;
      end
      if (ph_conv) begin
        j++;
        for (int c = 0; c < NC; c++) begin
          if (adc_pwr[c]) pw[c]++;
          if (adc_soc[c]) begin
            sc[c]++;
            if (fj[c] < 0) fj[c] = j;
            due[c] = j + cfg_lat[c];
          end
        end
        if (scramble && j == 1) begin
          ch_trig = ~tg;
          ch_samples = $urandom;
        end
      end else if (adc_pwr != '0 || adc_soc != '0) outside++;
      for (int c = 0; c < NC; c++) conv_done[c] = ph_conv && (due[c] == j);
      if (ph_read) begin
        rd_n++;
        if (rd_n == 1) for (int c = 0; c < NC; c++) ov[c] = ch_overrun[c];
      end
      if (ph_idle && rd_n > 0) break;
      @(negedge clk);
    end
    conv_done = '0;
    check("R2 acquisition length", acq_n, ACQ);
    check("R2 window length", j, CONV);
    check("R2 readout length", rd_n, READ);
    check("R2 one phase flag", multi, 0);
    check("R11 outputs outside window", outside, 0);
    check("R10 overrun cleared at frame start", ovr_acq, 0);
    for (int c = 0; c < NC; c++) begin
      int k = eff(tg[c], cfg_cnt[c]);
      int l = cfg_lat[c];
      check($sformatf("R5 R9 power cycles ch%0d", c), pw[c], exp_pwr(k, l));
      check($sformatf("R7 R8 strobe count ch%0d", c), sc[c], exp_socs(k, l));
      check($sformatf("R10 overrun ch%0d", c), ov[c], exp_ovr(k, l));
      if (exp_socs(k, l) > 0) check($sformatf("R6 first strobe ch%0d", c), fj[c], RECOV + 1);
    end
    repeat (5) @(negedge clk);
    check("R2 idle holds", int'(ph_idle), 1);
    check("R10 overrun held in idle", int'(ch_overrun[2]), ov[2]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cycle_start = 1'b0; ch_trig = '0; ch_samples = '0; conv_done = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idle", int'(ph_idle), 1);
    check("R1 other phases", int'({ph_acq, ph_conv, ph_read}), 0);
    check("R1 power", int'(adc_pwr), 0);
    check("R1 strobes", int'(adc_soc), 0);
    check("R1 overrun", int'(ch_overrun), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5 R8: untriggered, clamp of 7 to 5, zero count
    cfg_cnt = '{5, 5, 7, 0}; cfg_lat = '{3, 3, 15, 3};
    run_frame(4'b1101, 1'b0, 1'b0);
    // R10 R9: done on last window cycle with samples left; strobe on last window cycle
    cfg_cnt = '{5, 2, 3, 1}; cfg_lat = '{13, 54, 27, 1};
    run_frame(4'b1111, 1'b0, 1'b0);
    // R3 R4: start pulse during acquisition, inputs scrambled during window
    cfg_cnt = '{2, 4, 0, 5}; cfg_lat = '{6, 2, 4, 9};
    run_frame(4'b1011, 1'b1, 1'b1);
    for (int f = 0; f < 10; f++) begin
      logic [NC-1:0] tg = NC'($urandom);
      for (int c = 0; c < NC; c++) begin
        cfg_cnt[c] = $urandom_range(7, 0);
        cfg_lat[c] = $urandom_range(20, 1);
      end
      run_frame(tg, f[0], f[1]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule